// File: doc/BRIEF.md
# Transmit Descriptor Decoder with Segmentation Context

This block sits in the transmit path of a network controller, just after descriptor fetch. Each 128-bit descriptor arrives as a lower and an upper 64-bit word. The block sorts every descriptor into one of six kinds. It pulls out the buffer length and the interrupt-delay request, and it forms the upper word that is written back to mark the descriptor done. All of these appear one cycle later on registered outputs.

Alongside the per-descriptor decode, the block holds the TCP segmentation-offload context that carries from one descriptor to the next. Context descriptors supply the header length and the maximum segment size. Segmentation is armed in one of two ways: by a plain context descriptor with its segmentation flag set, or by an advanced data descriptor with its flag set that arrives while segmentation is idle. The block also checks that the descriptor meant to carry the packet header can hold that header. A violation sets a sticky fault output, and processing carries on.

The downstream data mover tells the block when the header has been loaded and when segmentation is finished.

Top module: `txd_parser`

## Requirements
- R1: After a synchronous reset, the following outputs are all 0: out_valid, tso_active, tso_start, tso_hdr_loaded and fault.
- R2: A descriptor accepted with desc_valid is reported one cycle later with out_valid high, and out_kind is set from the upper word. When bit 29 is 0, out_kind is 0 (legacy). Otherwise bits 23:20 select the kind: 0 gives out_kind 1 (context), 1 gives 2 (data), 2 gives 3 (advanced context), 3 gives 4 (advanced data), and any other value gives 5 (reserved).
- R3: out_buf_len is upper bits 15:0, zero-extended, for legacy descriptors, and upper bits 19:0 for every other kind.
- R4: out_irq_delay equals upper bit 31 for legacy and data descriptors, and is 0 for every other kind.
- R5: out_wb_hi is the upper word with bits 35:32 replaced by the value 1. All other bits are unchanged.
- R6: A context or advanced context descriptor loads tso_mss from upper bits 63:48. It also loads tso_hdr_len from upper bits 47:40. For advanced context, tso_hdr_len is instead the sum of upper bits 47:40, lower bits 8:0 and lower bits 15:9.
- R7: A context descriptor with upper bit 26 set arms segmentation, even if it is already armed, and sets tso_total_len to upper bits 19:0. An advanced context descriptor never arms segmentation.
- R8: An advanced data descriptor with upper bit 31 set arms segmentation only if segmentation is not already active, and then sets tso_total_len to upper bits 63:46. If segmentation is already active, the total is left unchanged.
- R9: Arming raises tso_start for exactly one cycle and clears tso_hdr_loaded. hdr_loaded_ack sets tso_hdr_loaded while segmentation is active. tso_clear deactivates segmentation and clears tso_hdr_loaded.
- R10: This rule applies while segmentation is active with the header not yet loaded. Any descriptor that is not a context kind must be data or advanced data, must have a length of at least tso_hdr_len, and tso_hdr_len must not exceed MAX_HDR (256). Any violation sets fault, which stays set until reset.
- R11: A data descriptor never arms segmentation, whatever the value of upper bits 26 and 31. An advanced data descriptor with only bit 26 set does not arm it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor present this cycle |
| desc_lo | input | 64 | Lower descriptor word |
| desc_hi | input | 64 | Upper descriptor word |
| hdr_loaded_ack | input | 1 | Segmentation header has been fetched |
| tso_clear | input | 1 | Segmentation of the current packet is finished |
| out_valid | output | 1 | Decode outputs are valid |
| out_kind | output | 3 | Descriptor kind code |
| out_buf_len | output | 20 | Buffer length |
| out_irq_delay | output | 1 | Interrupt-delay request honoured |
| out_wb_hi | output | 64 | Upper word to write back as done |
| tso_active | output | 1 | Segmentation armed |
| tso_start | output | 1 | One-cycle pulse when segmentation is armed |
| tso_hdr_loaded | output | 1 | Header loaded for the current segmentation |
| tso_hdr_len | output | 10 | Latched header length |
| tso_mss | output | 16 | Latched maximum segment size |
| tso_total_len | output | 20 | Total payload length for segmentation |
| fault | output | 1 | Sticky header-check violation |

## Verification
The bench targets the places where the formats overlap:

- The segmentation flag sits at bit 26 for some kinds and at bit 31 for advanced data. A design that reads the wrong bit would arm on a plain data descriptor or an advanced context descriptor, or would miss arming on advanced data.
- The advanced header length is a three-field sum. A design that skipped the sum would latch only the upper field.
- The advanced data total comes from bits 63:46. A design that let a second advanced data descriptor re-arm would overwrite that total.
- A legacy descriptor has bits 19:16 set, which exposes a length field that is too wide.
- Each of the three fault conditions is driven on its own. A design that dropped a condition, or let the fault clear itself, would fail those cases.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W = 64;
  localparam int LEN_W  = 20;
  localparam int HDR_W  = 10;
  localparam int MSS_W  = 16;
  localparam int TOT_W  = 20;
  localparam int ATOT_W = 18;

  typedef enum logic [2:0] {
    K_LEGACY = 3'd0,
    K_CTX    = 3'd1,
    K_DATA   = 3'd2,
    K_ACTX   = 3'd3,
    K_ADATA  = 3'd4,
    K_RSVD   = 3'd5
  } txd_kind_e;

  typedef struct packed {
    txd_kind_e           kind;
    logic                is_ctx;
    logic                is_data;
    logic [LEN_W-1:0]    len;
    logic                seg_flag;
    logic                irq_delay;
    logic [MSS_W-1:0]    mss;
    logic [HDR_W-1:0]    hdr;
    logic [ATOT_W-1:0]   adv_total;
  } txd_fields_t;
endpackage

// File: rtl/txd_classify.sv
module txd_classify
  import txd_pkg::*;
(
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] hi,
  output txd_fields_t       f
);
  logic      ext_fmt;
  logic [3:0] typ;

  always_comb begin
    ext_fmt = hi[29];
    typ     = hi[23:20];
    f       = '0;
    if (!ext_fmt) begin
      f.kind = K_LEGACY;
    end else begin
      case (typ)
        4'd0:    f.kind = K_CTX;
        4'd1:    f.kind = K_DATA;
        4'd2:    f.kind = K_ACTX;
        4'd3:    f.kind = K_ADATA;
        default: f.kind = K_RSVD;
      endcase
    end
    f.is_ctx  = (f.kind == K_CTX) || (f.kind == K_ACTX);
    f.is_data = (f.kind == K_DATA) || (f.kind == K_ADATA);
    f.len     = ext_fmt ? hi[19:0] : {4'b0, hi[15:0]};
    case (f.kind)
      K_CTX, K_DATA: f.seg_flag = hi[26];
      K_ADATA:       f.seg_flag = hi[31];
      default:       f.seg_flag = 1'b0;
    endcase
    f.irq_delay = hi[31] && ((f.kind == K_LEGACY) || (f.kind == K_DATA));
    f.mss       = hi[63:48];
    if (f.kind == K_ACTX)
      f.hdr = {2'b0, hi[47:40]} + {1'b0, lo[8:0]} + {3'b0, lo[15:9]};
    else
      f.hdr = {2'b0, hi[47:40]};
    f.adv_total = hi[63:46];
  end
endmodule

// File: rtl/txd_seg_ctx.sv
module txd_seg_ctx
  import txd_pkg::*;
#(
  parameter int MAX_HDR = 256
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  txd_fields_t       f,
  input  logic              hdr_ack,
  input  logic              clear,
  output logic              active,
  output logic              start,
  output logic              hdr_loaded,
  output logic [HDR_W-1:0]  hdr_len,
  output logic [MSS_W-1:0]  mss,
  output logic [TOT_W-1:0]  total,
  output logic              fault
);
  logic             act_n, hl_n, arm, viol;
  logic [HDR_W-1:0] hdr_n;
  logic [MSS_W-1:0] mss_n;
  logic [TOT_W-1:0] tot_n;

  always_comb begin
    act_n = active && !clear;
    hl_n  = clear ? 1'b0 : (hdr_loaded || (hdr_ack && active));
    hdr_n = hdr_len;
    mss_n = mss;
    tot_n = total;
    arm   = 1'b0;
    viol  = 1'b0;
    if (valid) begin
      if (f.is_ctx) begin
        hdr_n = f.hdr;
        mss_n = f.mss;
        if (f.kind == K_CTX && f.seg_flag) begin
          arm   = 1'b1;
          tot_n = f.len;
        end
      end else if (f.kind == K_ADATA && f.seg_flag && !act_n) begin
        arm   = 1'b1;
        tot_n = {{(TOT_W-ATOT_W){1'b0}}, f.adv_total};
      end
      if (arm) begin
        act_n = 1'b1;
        hl_n  = 1'b0;
      end
      if (!f.is_ctx && act_n && !hl_n) begin
        viol = !f.is_data
            || (f.len < {{(LEN_W-HDR_W){1'b0}}, hdr_n})
            || (int'(hdr_n) > MAX_HDR);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      start      <= 1'b0;
      hdr_loaded <= 1'b0;
      hdr_len    <= '0;
      mss        <= '0;
      total      <= '0;
      fault      <= 1'b0;
    end else begin
      active     <= act_n;
      start      <= arm;
      hdr_loaded <= hl_n;
      hdr_len    <= hdr_n;
      mss        <= mss_n;
      total      <= tot_n;
      fault      <= fault || viol;
    end
  end
endmodule

// File: rtl/txd_parser.sv
module txd_parser
  import txd_pkg::*;
#(
  parameter int MAX_HDR = 256
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  input  logic [63:0]       desc_lo,
  input  logic [63:0]       desc_hi,
  input  logic              hdr_loaded_ack,
  input  logic              tso_clear,
  output logic              out_valid,
  output logic [2:0]        out_kind,
  output logic [19:0]       out_buf_len,
  output logic              out_irq_delay,
  output logic [63:0]       out_wb_hi,
  output logic              tso_active,
  output logic              tso_start,
  output logic              tso_hdr_loaded,
  output logic [9:0]        tso_hdr_len,
  output logic [15:0]       tso_mss,
  output logic [19:0]       tso_total_len,
  output logic              fault
);
  localparam logic [3:0] DONE_CODE = 4'd1;

  txd_fields_t fld;

  txd_classify u_cls (
    .lo (desc_lo),
    .hi (desc_hi),
    .f  (fld)
  );

  txd_seg_ctx #(.MAX_HDR(MAX_HDR)) u_ctx (
    .clk        (clk),
    .rst        (rst),
    .valid      (desc_valid),
    .f          (fld),
    .hdr_ack    (hdr_loaded_ack),
    .clear      (tso_clear),
    .active     (tso_active),
    .start      (tso_start),
    .hdr_loaded (tso_hdr_loaded),
    .hdr_len    (tso_hdr_len),
    .mss        (tso_mss),
    .total      (tso_total_len),
    .fault      (fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_kind      <= K_LEGACY;
      out_buf_len   <= '0;
      out_irq_delay <= 1'b0;
      out_wb_hi     <= '0;
    end else begin
      out_valid <= desc_valid;
      if (desc_valid) begin
        out_kind      <= fld.kind;
        out_buf_len   <= fld.len;
        out_irq_delay <= fld.irq_delay;
        out_wb_hi     <= {desc_hi[63:36], DONE_CODE, desc_hi[31:0]};
      end
    end
  end
endmodule

// File: rtl/txd_parser_chk.sv
module txd_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        desc_valid,
  input logic [63:0] desc_hi,
  input logic        out_valid,
  input logic [63:0] out_wb_hi,
  input logic        tso_active,
  input logic        tso_start,
  input logic        tso_hdr_loaded,
  input logic        fault
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !tso_active && !tso_start && !fault));

  assert_one_cycle_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(desc_valid));

  assert_done_code_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_wb_hi[35:32] == 4'd1 && out_wb_hi[63:36] == $past(desc_hi[63:36])
                   && out_wb_hi[31:0] == $past(desc_hi[31:0])));

  assert_start_state_R9: assert property (@(posedge clk) disable iff (rst)
    tso_start |-> (tso_active && !tso_hdr_loaded));

  assert_arm_pulses_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tso_active) |-> tso_start);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(fault) |-> fault);
endmodule

bind txd_parser txd_parser_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .desc_valid     (desc_valid),
  .desc_hi        (desc_hi),
  .out_valid      (out_valid),
  .out_wb_hi      (out_wb_hi),
  .tso_active     (tso_active),
  .tso_start      (tso_start),
  .tso_hdr_loaded (tso_hdr_loaded),
  .fault          (fault)
);

// File: tb/txd_parser_tb.sv
module txd_parser_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic        desc_valid;
  logic [63:0] desc_lo, desc_hi;
  logic        hdr_loaded_ack, tso_clear;
  logic        out_valid;
  logic [2:0]  out_kind;
  logic [19:0] out_buf_len;
  logic        out_irq_delay;
  logic [63:0] out_wb_hi;
  logic        tso_active, tso_start, tso_hdr_loaded;
  logic [9:0]  tso_hdr_len;
  logic [15:0] tso_mss;
  logic [19:0] tso_total_len;
  logic        fault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_parser u_dut (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_lo(desc_lo), .desc_hi(desc_hi),
    .hdr_loaded_ack(hdr_loaded_ack), .tso_clear(tso_clear),
    .out_valid(out_valid), .out_kind(out_kind), .out_buf_len(out_buf_len),
    .out_irq_delay(out_irq_delay), .out_wb_hi(out_wb_hi),
    .tso_active(tso_active), .tso_start(tso_start), .tso_hdr_loaded(tso_hdr_loaded),
    .tso_hdr_len(tso_hdr_len), .tso_mss(tso_mss), .tso_total_len(tso_total_len),
    .fault(fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit ext, input logic [3:0] typ, input logic [19:0] len,
                                     input bit b26, input bit b31, input logic [15:0] mss,
                                     input logic [7:0] hdr);
    logic [63:0] h;
    h = '0;
    h[19:0]  = len;
    h[23:20] = typ;
    h[26]    = b26;
    h[29]    = ext;
    h[31]    = b31;
    h[47:40] = hdr;
    h[63:48] = mss;
    return h;
  endfunction

  function automatic logic [63:0] wb(input logic [63:0] h);
    return (h & ~(64'hF << 32)) | (64'h1 << 32);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; desc_valid = 0; desc_lo = '0; desc_hi = '0; hdr_loaded_ack = 0; tso_clear = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic send(input logic [63:0] lo, input logic [63:0] hi);
    desc_lo = lo; desc_hi = hi; desc_valid = 1;
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic pulse_ack();
    hdr_loaded_ack = 1; @(negedge clk); hdr_loaded_ack = 0;
  endtask

  task automatic pulse_clear();
    tso_clear = 1; @(negedge clk); tso_clear = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!out_valid && !tso_active && !tso_start && !tso_hdr_loaded && !fault, "R1 reset state",
        {out_valid, tso_active, tso_start, tso_hdr_loaded, fault}, 0);
  endtask

  task automatic t_decode();
    logic [63:0] h;
    do_reset();
    h = mk(0, 4'h3, 20'hF1234, 1, 1, 16'h0, 8'h0);
    send(64'h55, h);
    chk(out_valid, "R2 valid after one cycle", out_valid, 1);
    chk(out_kind == 3'd0, "R2 legacy kind", out_kind, 0);
    chk(out_buf_len == 20'h01234, "R3 legacy length", out_buf_len, 20'h01234);
    chk(out_irq_delay == 1, "R4 legacy irq delay", out_irq_delay, 1);
    chk(out_wb_hi == wb(h), "R5 writeback legacy", out_wb_hi, wb(h));
    @(negedge clk);
    chk(!out_valid, "R2 valid drops", out_valid, 0);
    h = mk(1, 4'h1, 20'hABCDE, 1, 1, 16'h0, 8'h0) | (64'hF << 32);
    send(0, h);
    chk(out_kind == 3'd2, "R2 data kind", out_kind, 2);
    chk(out_buf_len == 20'hABCDE, "R3 data length", out_buf_len, 20'hABCDE);
    chk(out_irq_delay == 1, "R4 data irq delay", out_irq_delay, 1);
    chk(out_wb_hi == wb(h), "R5 writeback clears field", out_wb_hi, wb(h));
    chk(!tso_active && !tso_start, "R11 data never arms", tso_active, 0);
    h = mk(1, 4'h3, 20'h100, 1, 0, 16'h0, 8'h0);
    send(0, h);
    chk(out_kind == 3'd4, "R2 adv data kind", out_kind, 4);
    chk(out_irq_delay == 0, "R4 adv data no irq delay", out_irq_delay, 0);
    chk(!tso_active, "R11 adv data bit26 no arm", tso_active, 0);
    send(0, mk(1, 4'h7, 20'h5, 0, 1, 16'h0, 8'h0));
    chk(out_kind == 3'd5, "R2 reserved kind", out_kind, 5);
    chk(out_irq_delay == 0, "R4 reserved no irq delay", out_irq_delay, 0);
    chk(!fault, "R10 no fault while idle", fault, 0);
  endtask

  task automatic t_ctx_arm();
    do_reset();
    send(0, mk(1, 4'h0, 20'd9000, 1, 0, 16'd1460, 8'd54));
    chk(out_kind == 3'd1, "R2 context kind", out_kind, 1);
    chk(tso_mss == 16'd1460 && tso_hdr_len == 10'd54, "R6 context latch",
        {tso_mss, 6'b0, tso_hdr_len}, {16'd1460, 6'b0, 10'd54});
    chk(tso_active && tso_start && !tso_hdr_loaded, "R7 context arms", {tso_active, tso_start, tso_hdr_loaded}, 3'b110);
    chk(tso_total_len == 20'd9000, "R7 total from length", tso_total_len, 20'd9000);
    send(0, mk(1, 4'h1, 20'd100, 0, 0, 16'h0, 8'h0));
    chk(!tso_start, "R9 start single cycle", tso_start, 0);
    chk(!fault, "R10 large enough data ok", fault, 0);
    pulse_ack();
    chk(tso_hdr_loaded, "R9 ack sets loaded", tso_hdr_loaded, 1);
    send(0, mk(0, 4'h0, 20'd4, 0, 0, 16'h0, 8'h0));
    chk(!fault, "R10 no check once loaded", fault, 0);
    send(0, mk(1, 4'h0, 20'd700, 1, 0, 16'd536, 8'd40));
    chk(tso_start && !tso_hdr_loaded && tso_total_len == 20'd700, "R7 rearm while active", tso_total_len, 20'd700);
    pulse_clear();
    chk(!tso_active && !tso_hdr_loaded, "R9 clear deactivates", tso_active, 0);
  endtask

  task automatic t_adv();
    logic [63:0] h, lo;
    do_reset();
    lo = '0; lo[8:0] = 9'd20; lo[15:9] = 7'd20;
    send(lo, mk(1, 4'h2, 20'd0, 1, 0, 16'd1448, 8'd14));
    chk(out_kind == 3'd3, "R2 adv context kind", out_kind, 3);
    chk(tso_hdr_len == 10'd54, "R6 adv header sum", tso_hdr_len, 10'd54);
    chk(tso_mss == 16'd1448, "R6 adv mss", tso_mss, 16'd1448);
    chk(!tso_active, "R7 adv context does not arm", tso_active, 0);
    h = mk(1, 4'h3, 20'd200, 0, 1, 16'h0, 8'h0) | ({46'b0, 18'h12345} << 46);
    send(0, h);
    chk(tso_active && tso_start, "R8 adv data arms", tso_active, 1);
    chk(tso_total_len == 20'h12345, "R8 adv total", tso_total_len, 20'h12345);
    chk(!fault, "R10 adv data carries header", fault, 0);
    h = mk(1, 4'h3, 20'd200, 0, 1, 16'h0, 8'h0) | ({46'b0, 18'h00777} << 46);
    send(0, h);
    chk(tso_total_len == 20'h12345 && !tso_start, "R8 no rearm while active", tso_total_len, 20'h12345);
    chk(tso_hdr_len == 10'd54, "R6 header held by data", tso_hdr_len, 10'd54);
  endtask

  task automatic t_faults();
    logic [63:0] lo;
    do_reset();
    send(0, mk(1, 4'h0, 20'd900, 1, 0, 16'd100, 8'd54));
    send(0, mk(0, 4'h0, 20'd500, 0, 0, 16'h0, 8'h0));
    chk(fault, "R10 legacy after arm faults", fault, 1);
    repeat (3) @(negedge clk);
    chk(fault, "R10 fault sticky", fault, 1);
    do_reset();
    send(0, mk(1, 4'h0, 20'd900, 1, 0, 16'd100, 8'd54));
    send(0, mk(1, 4'h1, 20'd53, 0, 0, 16'h0, 8'h0));
    chk(fault, "R10 short data faults", fault, 1);
    do_reset();
    lo = '0; lo[8:0] = 9'd511; lo[15:9] = 7'd127;
    send(lo, mk(1, 4'h2, 20'd0, 0, 0, 16'd100, 8'd255));
    chk(tso_hdr_len == 10'd893, "R6 adv header max sum", tso_hdr_len, 10'd893);
    chk(!fault, "R10 inactive no fault", fault, 0);
    send(0, mk(1, 4'h3, 20'hFFFFF, 0, 1, 16'h0, 8'h0));
    chk(fault, "R10 oversize header faults", fault, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; desc_valid = 0; desc_lo = '0; desc_hi = '0; hdr_loaded_ack = 0; tso_clear = 0;
    t_reset();
    t_decode();
    t_ctx_arm();
    t_adv();
    t_faults();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule